// File: doc/BRIEF.md
# Serial Channel Interrupt Aggregator

This block gathers the interrupt events of four serial channels into one interrupt line. Each channel owns an 8-bit lane of a 32-bit raw status word. A one-cycle strobe on a channel event sets the matching status bit, and the bit stays set until software acknowledges it. A 32-bit enable mask selects which status bits may drive the interrupt line. Software cannot write the mask directly. It changes only through an enable-set register and an enable-clear register, so two agents can each adjust their own bits without a read-modify-write race.

Software reaches the block over a small register bus with a write strobe, a 2-bit address, write data and combinational read data. A fourth address returns the raw status ANDed with the mask. This lets a handler see every enabled pending event in one read.

Top module: `sio_irq_agg`

## Requirements
- R1: While rst_n is low at a rising clock edge, the raw status and the enable mask are cleared to zero, so after reset every read returns 0 and irq_o is low.
- R2: A one-cycle high on port_evt bit 8n+k sets raw status bit 8n+k at that clock edge. For channel n, lane bit k is ordered from the LSB as: 0 TX empty, 1 RX buffer full, 2 RX high-water, 3 RX timeout, 4 DCD change, 5 CTS change, 6 pass-through, 7 TX done.
- R3: A raw status bit stays set after its strobe ends, whether or not it is enabled, until a write acknowledges it.
- R4: A write to address 0 clears every raw status bit written as 1 and leaves bits written as 0 unchanged. A read of address 0 returns the raw status.
- R5: When a strobe and an acknowledging write hit the same raw bit in the same cycle, the bit ends up set.
- R6: A write to address 1 sets each mask bit written as 1. Mask bits written as 0 do not change.
- R7: A write to address 2 clears each mask bit written as 1. Mask bits written as 0 do not change.
- R8: A read of address 1 or address 2 returns the current enable mask.
- R9: A read of address 3 returns the raw status ANDed with the enable mask.
- R10: irq_o is high exactly when at least one bit is set in both the raw status and the mask. It follows the registered state with no added cycle.
- R11: A write to address 3 has no effect on the raw status or on the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 raw status, 1 enable set, 2 enable clear, 3 pending |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| port_evt | input | 32 | Event strobes, lane n at bits [8n+7:8n] |
| irq_o | output | 1 | Combined active-high interrupt |

## Verification
The assertions assume that each event strobe is a sampled synchronous level that counts once per clock edge it is high. They also assume that one bus write names exactly one register, so a single operation never sets and clears the same mask bit. The stimulus drives every strobe and every write for one clock period between falling edges and issues one bus operation at a time. It keeps strobes and writes idle during reads, so a sampled read reflects only state already committed. The one deliberate overlap is a strobe issued together with an acknowledge of the same bit, which is the corner case R5 covers.

// File: rtl/sio_irq_pkg.sv
// Package: shared constants for the serial interrupt aggregator.
// Assumes: each channel lane is 8 bits and the register map has four addresses.
package sio_irq_pkg;

    localparam int LANE_BITS = 8;

    // Position of each event inside a channel lane (LSB first).
    typedef enum int {
        EV_TX_EMPTY = 0,
        EV_RX_FULL  = 1,
        EV_RX_HIGH  = 2,
        EV_RX_TMO   = 3,
        EV_DCD_CHG  = 4,
        EV_CTS_CHG  = 5,
        EV_PASS     = 6,
        EV_TX_DONE  = 7
    } lane_evt_e;

    // Register map addresses.
    localparam logic [1:0] ADR_RAW    = 2'd0;
    localparam logic [1:0] ADR_EN_SET = 2'd1;
    localparam logic [1:0] ADR_EN_CLR = 2'd2;
    localparam logic [1:0] ADR_PEND   = 2'd3;

endpackage

// File: rtl/irq_status_lane.sv
// Module: one channel lane of sticky raw status bits.
// Does:   sets a bit on an event strobe and clears it on a write-one acknowledge.
//         A strobe wins over an acknowledge of the same bit.
// Assumes: ack_i is already qualified by the bus write strobe and address decode.
module irq_status_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] ack_i,
    output logic [W-1:0] raw_o
);

    logic [W-1:0] raw_q;

    // Sticky status update: acknowledge first, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else begin
            raw_q <= (raw_q & ~ack_i) | evt_i;
        end
    end

    assign raw_o = raw_q;

endmodule

// File: rtl/irq_mask_reg.sv
// Module: enable mask changed only through set and clear vectors.
// Does:   bits written 1 on set_i become enabled, bits written 1 on clr_i become
//         disabled, and zero bits leave the mask alone.
// Assumes: set_i and clr_i come from different addresses, so they never overlap.
module irq_mask_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] mask_o
);

    logic [W-1:0] mask_q;

    // Mask update from the set and clear vectors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= (mask_q & ~clr_i) | set_i;
        end
    end

    assign mask_o = mask_q;

endmodule

// File: rtl/irq_rd_mux.sv
// Module: read data select and pending reduction.
// Does:   picks raw status, mask or the masked status for the read address, and
//         reduces the masked status into the interrupt line.
// Assumes: the read is combinational; the caller registers it if timing needs it.
module irq_rd_mux
    import sio_irq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]   addr_i,
    input  logic [W-1:0] raw_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] rdata_o,
    output logic         pend_o
);

    logic [W-1:0] pend_vec;

    // Masked status and its OR reduction.
    always_comb begin
        pend_vec = raw_i & mask_i;
        pend_o   = |pend_vec;
    end

    // Read data select by address.
    always_comb begin
        unique case (addr_i)
            ADR_RAW:    rdata_o = raw_i;
            ADR_EN_SET: rdata_o = mask_i;
            ADR_EN_CLR: rdata_o = mask_i;
            default:    rdata_o = pend_vec;
        endcase
    end

endmodule

// File: rtl/sio_irq_agg.sv
// Module: interrupt aggregator for several serial channels (top).
// Does:   holds per-channel sticky status lanes and a set/clear enable mask,
//         decodes bus writes into acknowledge/set/clear vectors, and drives a
//         combined interrupt from status AND mask.
// Assumes: one bus operation per cycle; event strobes are synchronous to clk.
module sio_irq_agg
    import sio_irq_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int LANE_W    = LANE_BITS,
    localparam int DATA_W   = NUM_PORTS * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] port_evt,
    output logic              irq_o
);

    logic [DATA_W-1:0] ack_vec;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] clr_vec;
    logic [DATA_W-1:0] raw_q;
    logic [DATA_W-1:0] mask_q;

    // Write decode: each address turns the write data into one action vector.
    always_comb begin
        ack_vec = '0;
        set_vec = '0;
        clr_vec = '0;
        if (reg_wr) begin
            unique case (reg_addr)
                ADR_RAW:    ack_vec = reg_wdata;
                ADR_EN_SET: set_vec = reg_wdata;
                ADR_EN_CLR: clr_vec = reg_wdata;
                default:    ;
            endcase
        end
    end

    // One sticky status lane per channel.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
        irq_status_lane #(
            .W (LANE_W)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .evt_i (port_evt[p*LANE_W +: LANE_W]),
            .ack_i (ack_vec[p*LANE_W +: LANE_W]),
            .raw_o (raw_q[p*LANE_W +: LANE_W])
        );
    end

    irq_mask_reg #(
        .W (DATA_W)
    ) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .mask_o (mask_q)
    );

    irq_rd_mux #(
        .W (DATA_W)
    ) u_rd (
        .addr_i  (reg_addr),
        .raw_i   (raw_q),
        .mask_i  (mask_q),
        .rdata_o (reg_rdata),
        .pend_o  (irq_o)
    );

endmodule

// File: rtl/sio_irq_agg_chk.sv
// Module: property checker for the interrupt aggregator, bound to the top.
// Assumes: synchronous active-low reset; one bus operation per cycle.
module sio_irq_agg_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         reg_wr,
    input logic [1:0]   reg_addr,
    input logic [W-1:0] reg_wdata,
    input logic [W-1:0] port_evt,
    input logic         irq_o,
    input logic [W-1:0] raw_q,
    input logic [W-1:0] mask_q
);

    AST_RST_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (raw_q == '0 && mask_q == '0)); // R1

    AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (port_evt != '0) |=> ((raw_q & $past(port_evt)) == $past(port_evt))); // R2

    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == 2'd0) |=> ((raw_q & $past(raw_q)) == $past(raw_q))); // R3

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0) |=>
            ((raw_q & $past(reg_wdata) & ~$past(port_evt)) == '0)); // R4

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && (reg_wdata & port_evt) != '0) |=>
            ((raw_q & $past(reg_wdata & port_evt)) == $past(reg_wdata & port_evt))); // R5

    AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1) |=>
            ((mask_q & $past(reg_wdata)) == $past(reg_wdata))); // R6

    AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2) |=> ((mask_q & $past(reg_wdata)) == '0)); // R7

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && (reg_addr == 2'd1 || reg_addr == 2'd2)) |=> $stable(mask_q)); // R11

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && (port_evt & mask_q) != '0) |=> irq_o); // R10

endmodule

bind sio_irq_agg sio_irq_agg_chk #(
    .W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .port_evt  (port_evt),
    .irq_o     (irq_o),
    .raw_q     (raw_q),
    .mask_q    (mask_q)
);

// File: tb/sio_irq_agg_bench.sv
// Scoreboard bench: driver tasks keep a requirement-level model and push the
// expected read word and interrupt level; a monitor pops and compares.
module sio_irq_agg_bench;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] port_evt = '0;
    logic [DW-1:0] reg_rdata;
    logic          irq_o;

    typedef struct {
        logic [DW-1:0] data;
        logic          irq;
        string         tag;
    } exp_t;

    exp_t          sb_q[$];
    logic          rd_go = 1'b0;
    logic [DW-1:0] m_raw = '0;
    logic [DW-1:0] m_mask = '0;
    int            n_cmp = 0;
    int            n_bad = 0;
    bit            done = 0;

    always #10 clk = ~clk;

    sio_irq_agg u_sio_irq_agg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .port_evt  (port_evt),
        .irq_o     (irq_o)
    );

    // Monitor: sample halfway between edges and compare against the queue.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rd_go && sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_cmp++;
                if (reg_rdata !== e.data || irq_o !== e.irq) begin
                    n_bad++;
                    $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                             e.tag, reg_rdata, irq_o, e.data, e.irq);
                end
            end
        end
    end

    task automatic bus_op(input logic wr, input logic [1:0] a,
                          input logic [DW-1:0] d, input logic [DW-1:0] ev);
        @(negedge clk);
        reg_wr    = wr;
        reg_addr  = a;
        reg_wdata = d;
        port_evt  = ev;
        if (rst_n) begin
            if (wr && a == 2'd0) m_raw = m_raw & ~d;
            if (wr && a == 2'd1) m_mask = m_mask | d;
            if (wr && a == 2'd2) m_mask = m_mask & ~d;
            m_raw = m_raw | ev;
        end
        @(negedge clk);
        reg_wr   = 1'b0;
        port_evt = '0;
    endtask

    task automatic read_chk(input logic [1:0] a, input string tag);
        exp_t e;
        @(negedge clk);
        reg_addr = a;
        case (a)
            2'd0:    e.data = m_raw;
            2'd1:    e.data = m_mask;
            2'd2:    e.data = m_mask;
            default: e.data = m_raw & m_mask;
        endcase
        e.irq = |(m_raw & m_mask);
        e.tag = tag;
        sb_q.push_back(e);
        rd_go = 1'b1;
        @(negedge clk);
        rd_go = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        m_raw  = '0;
        m_mask = '0;
        rst_n  = 1'b1;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        read_chk(2'd0, "R1 raw after reset");
        read_chk(2'd1, "R1 mask after reset");

        // R2: channel 0 TX empty (bit 0)
        bus_op(1'b0, 2'd0, '0, 32'h0000_0001);
        read_chk(2'd0, "R2 ch0 tx-empty bit0");
        // R2: channel 2 CTS change (bit 21) and channel 3 TX done (bit 31)
        bus_op(1'b0, 2'd0, '0, 32'h8020_0000);
        read_chk(2'd0, "R2 ch2 cts / ch3 txdone");
        repeat (4) @(negedge clk);
        read_chk(2'd0, "R3 sticky while disabled");

        // R6/R8/R9/R10
        bus_op(1'b1, 2'd1, 32'h0000_0001, '0);
        read_chk(2'd1, "R6 set bit0 / R8 readback");
        read_chk(2'd3, "R9 pending / R10 irq high");
        bus_op(1'b1, 2'd1, 32'h0020_0000, '0);
        read_chk(2'd1, "R6 zero bits unchanged");

        // R7
        bus_op(1'b1, 2'd2, 32'h0000_0001, '0);
        read_chk(2'd2, "R7 clear bit0 / R8 addr2 readback");

        // R4
        bus_op(1'b1, 2'd0, 32'h0000_0001, '0);
        read_chk(2'd0, "R4 ack bit0");

        // R5: event and ack of bit 21 together
        bus_op(1'b1, 2'd0, 32'h0020_0000, 32'h0020_0000);
        read_chk(2'd0, "R5 event wins over ack");
        read_chk(2'd3, "R10 irq still set");

        // R4/R10: clear all remaining
        bus_op(1'b1, 2'd0, 32'h8020_0000, '0);
        read_chk(2'd0, "R4 ack all");
        read_chk(2'd3, "R10 irq low");

        // R11: write to pending address ignored
        bus_op(1'b0, 2'd0, '0, 32'h0000_0400);
        bus_op(1'b1, 2'd3, 32'hFFFF_FFFF, '0);
        read_chk(2'd0, "R11 raw unchanged");
        read_chk(2'd1, "R11 mask unchanged");

        // Multi-lane pattern, partial enable
        bus_op(1'b0, 2'd0, '0, 32'h5A3C_81FE);
        bus_op(1'b1, 2'd1, 32'h0F0F_00F0, '0);
        read_chk(2'd3, "R9 multi-lane pending");
        read_chk(2'd0, "R2 multi-lane raw");
        bus_op(1'b1, 2'd2, 32'hFFFF_FFFF, '0);
        read_chk(2'd3, "R10 all disabled irq low");

        // R1: reset after activity
        bus_op(1'b1, 2'd1, 32'hFFFF_FFFF, '0);
        do_reset();
        read_chk(2'd0, "R1 raw after second reset");
        read_chk(2'd1, "R1 mask after second reset");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: %0d items left expected=0", sb_q.size());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule